// File: doc/BRIEF.md
# Infrared Serial Pulse Shaper

This block sits between an ordinary UART and the two serial pins of a chip and converts between full-width NRZ bits and the short light pulses used by infrared serial links at rates up to 115.2 kbps. It is meant for the UART's 8-bit asynchronous framing, with transmit and receive sharing one baud rate. On the transmit side every zero bit leaving the UART becomes one short high pulse on the pin, and a one bit leaves the pin low. On the receive side every rising edge seen on the pin becomes one full bit time of low level on the UART's receive line.

The UART's baud generator supplies a strobe at sixteen times the bit rate. The shaper uses it to track bit boundaries and to time the short pulse and the receive stretch. A single 8-bit control register holds three fields. An enable bit switches the shaper in and out. A mode bit chooses a pulse of three sixteenths of a bit or a fixed-width pulse. A 5-bit divider sets the period of the reference tick that times the fixed pulse. While the shaper is disabled, both signals pass through, each behind one register.

Top module: `ir_pulse_shaper`

## Requirements
- R1: After reset, the control register reads 0x0F and the shaper is disabled: bit 6 is 0, bit 5 is 0 and bits 4:0 are 15.
- R2: The control register layout is as follows. Bit 6 is the enable, bit 5 the mode (1 = 3/16 bit, 0 = fixed width) and bits 4:0 the divider. A write stores bits 6:0 and bit 7 always reads 0.
- R3: While disabled, `pin_tx` equals `uart_txd` one clock earlier and `uart_rxd` equals `pin_rx` one clock earlier.
- R4: While enabled with an idle line (`uart_txd` high, `pin_rx` low), `pin_tx` stays low and `uart_rxd` stays high.
- R5: In 3/16 mode, each zero bit of a frame gives exactly one high pulse on `pin_tx`. The pulse lasts 3 strobe periods and begins at the start of the bit. The bit phase is taken from each falling edge of `uart_txd`, and a new bit begins every 16 strobes.
- R6: A one bit produces no pulse, so a frame gives as many pulses as it has zero bits (start bit included).
- R7: In fixed mode, each pulse lasts FIX_TICKS × (divider + 1) clocks. A reference tick occurs every divider + 1 clocks, counted from the start of the pulse.
- R8: With the shaper enabled, a rising edge on `pin_rx` drives `uart_rxd` low for 16 strobes after two synchroniser stages. The low time is longer than 15 and at most 16 strobe periods.
- R9: A rising edge on `pin_rx` during a stretch restarts the 16-strobe count.
- R10: A write that changes the enable bit cancels any transmit pulse or receive stretch in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| baud_tick16 | input | 1 | One-clock strobe at 16 times the bit rate |
| uart_txd | input | 1 | Serial data from the UART transmitter |
| uart_rxd | output | 1 | Serial data to the UART receiver |
| pin_tx | output | 1 | Transmit pin (high = light on) |
| pin_rx | input | 1 | Receive pin (high = light detected) |

## Verification
The bench sends random bytes with back-to-back zero bits in both pulse modes and with random divider values, then compares every pulse width and the pulse count against values it computes itself. A shaper that merges adjacent zero bits, pulses on one bits or miscounts the reference prescaler by one gives a wrong count or width. On receive, it checks both the single-stretch window and a retriggered stretch, which a design without restart would cut short. It also toggles the enable bit in the middle of a fixed-width pulse and in the middle of a stretch; a design that does not cancel them would leave the pin lit or the receive line held low.

// File: rtl/ir_shaper_pkg.sv
package ir_shaper_pkg;

  localparam int DIV_W    = 5;
  localparam int REG_W    = 8;
  localparam int EN_BIT   = 6;
  localparam logic [REG_W-1:0] CTL_RESET = 8'h0F;

  typedef struct packed {
    logic             en;     // shaper in the path
    logic             frac;   // 1: 3/16 bit pulse, 0: fixed width pulse
    logic [DIV_W-1:0] div;    // reference prescaler reload
  } ir_ctl_t;

endpackage

// File: rtl/ir_ctl_reg.sv
module ir_ctl_reg
  import ir_shaper_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output ir_ctl_t          ctl,
  output logic             clr
);

  ir_ctl_t ctl_q;
  logic    unused_top_bit;

  assign unused_top_bit = wdata[REG_W-1];

  always_ff @(posedge clk) begin
    if (rst)     ctl_q <= ir_ctl_t'(CTL_RESET[REG_W-2:0]);
    else if (wr) ctl_q <= ir_ctl_t'(wdata[REG_W-2:0]);
  end

  assign ctl   = ctl_q;
  assign rdata = {1'b0, ctl_q};
  // shaping state is held clear while disabled and on any enable change
  assign clr   = ~ctl_q.en | (wr & (wdata[EN_BIT] != ctl_q.en));

  // R2
  rd_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> (rdata[REG_W-1] == 1'b0) && (rdata[REG_W-2:0] == $past(wdata[REG_W-2:0])));

endmodule

// File: rtl/ir_tx_shaper.sv
module ir_tx_shaper
  import ir_shaper_pkg::*;
#(
  parameter int BIT_TICKS   = 16,
  parameter int SHORT_TICKS = 3,
  parameter int FIX_TICKS   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic             txd,
  input  logic             frac,
  input  logic [DIV_W-1:0] div,
  output logic             pulse
);

  localparam int PH_W  = $clog2(BIT_TICKS);
  localparam int MAXT  = (FIX_TICKS > SHORT_TICKS) ? FIX_TICKS : SHORT_TICKS;
  localparam int CNT_W = $clog2(MAXT + 1);
  localparam logic [PH_W-1:0]  PH_LAST    = PH_W'(BIT_TICKS - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_TICKS - 1);
  localparam logic [CNT_W-1:0] FIX_LAST   = CNT_W'(FIX_TICKS - 1);

  logic             txd_d;
  logic [PH_W-1:0]  ph;
  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] pre;
  logic             fall, wrap, start;

  assign fall  = txd_d & ~txd;
  assign wrap  = tick & (ph == PH_LAST);
  assign start = fall | (wrap & ~txd);

  // bit phase: restarted by every falling edge, advanced by strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      txd_d <= 1'b1;
      ph    <= '0;
    end else if (clr) begin
      txd_d <= txd;
      ph    <= '0;
    end else begin
      txd_d <= txd;
      if (fall)      ph <= '0;
      else if (tick) ph <= ph + 1'b1;
    end
  end

  // pulse timer: strobe counted in 3/16 mode, prescaled clock in fixed mode
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pulse <= 1'b0;
      cnt   <= '0;
      pre   <= '0;
    end else if (start) begin
      pulse <= 1'b1;
      cnt   <= '0;
      pre   <= div;
    end else if (pulse) begin
      if (!frac) begin
        if (pre == '0) begin
          pre <= div;
          cnt <= cnt + 1'b1;
          if (cnt == FIX_LAST) pulse <= 1'b0;
        end else begin
          pre <= pre - 1'b1;
        end
      end else if (tick) begin
        cnt <= cnt + 1'b1;
        if (cnt == SHORT_LAST) pulse <= 1'b0;
      end
    end
  end

  // R10
  tx_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !pulse);

  // R6
  tx_zero_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse) |-> !$past(txd));

endmodule

// File: rtl/ir_rx_stretch.sv
module ir_rx_stretch #(
  parameter int BIT_TICKS = 16,
  parameter int SYNC      = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  input  logic pin,
  output logic stretch
);

  localparam int SC_W = $clog2(BIT_TICKS);
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(BIT_TICKS - 1);

  logic [SYNC:0]   sh;
  logic [SC_W-1:0] scnt;
  logic            rise;

  // synchroniser plus one edge-detect stage
  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC-1:0], pin};
  end

  assign rise = sh[SYNC-1] & ~sh[SYNC];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      stretch <= 1'b0;
      scnt    <= '0;
    end else if (rise) begin
      stretch <= 1'b1;
      scnt    <= '0;
    end else if (stretch && tick) begin
      scnt <= scnt + 1'b1;
      if (scnt == SC_LAST) stretch <= 1'b0;
    end
  end

  // R10
  rx_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !stretch);

  // R9
  rx_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && !clr) |=> (stretch && scnt == '0));

endmodule

// File: rtl/ir_pulse_shaper.sv
module ir_pulse_shaper
  import ir_shaper_pkg::*;
#(
  parameter int BIT_TICKS   = 16,
  parameter int SHORT_TICKS = 3,
  parameter int FIX_TICKS   = 10,
  parameter int SYNC        = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       baud_tick16,
  input  logic       uart_txd,
  output logic       uart_rxd,
  output logic       pin_tx,
  input  logic       pin_rx
);

  ir_ctl_t ctl;
  logic    clr, pulse, stretch;

  ir_ctl_reg u_ctl (
    .clk   (clk),
    .rst   (rst),
    .wr    (reg_wr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .ctl   (ctl),
    .clr   (clr)
  );

  ir_tx_shaper #(
    .BIT_TICKS   (BIT_TICKS),
    .SHORT_TICKS (SHORT_TICKS),
    .FIX_TICKS   (FIX_TICKS)
  ) u_tx (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .tick  (baud_tick16),
    .txd   (uart_txd),
    .frac  (ctl.frac),
    .div   (ctl.div),
    .pulse (pulse)
  );

  ir_rx_stretch #(
    .BIT_TICKS (BIT_TICKS),
    .SYNC      (SYNC)
  ) u_rx (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .tick    (baud_tick16),
    .pin     (pin_rx),
    .stretch (stretch)
  );

  // registered pin-side and UART-side outputs, shaper or bypass
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_tx   <= 1'b1;
      uart_rxd <= 1'b1;
    end else begin
      pin_tx   <= ctl.en ? pulse    : uart_txd;
      uart_rxd <= ctl.en ? ~stretch : pin_rx;
    end
  end

  // R3
  byp_tx_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.en |=> (pin_tx == $past(uart_txd)));

  // R3
  byp_rx_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.en |=> (uart_rxd == $past(pin_rx)));

endmodule

// File: tb/ir_pulse_shaper_tb.sv
module ir_pulse_shaper_tb_top;

  localparam int P   = 16;   // clocks per strobe
  localparam int FIX = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       baud_tick16 = 1'b0;
  logic       uart_txd = 1'b1;
  logic       uart_rxd;
  logic       pin_tx;
  logic       pin_rx = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  ir_pulse_shaper #(.FIX_TICKS(FIX)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .baud_tick16(baud_tick16), .uart_txd(uart_txd),
    .uart_rxd(uart_rxd), .pin_tx(pin_tx), .pin_rx(pin_rx)
  );

  // run-length monitors
  int tx_run = 0, tx_n = 0;
  int tx_w [0:255];
  int rx_run = 0, rx_n = 0;
  int rx_w [0:255];

  always @(negedge clk) begin
    if (!rst) begin
      if (pin_tx) tx_run++;
      else if (tx_run != 0) begin tx_w[tx_n % 256] = tx_run; tx_n++; tx_run = 0; end
      if (!uart_rxd) rx_run++;
      else if (rx_run != 0) begin rx_w[rx_n % 256] = rx_run; rx_n++; rx_run = 0; end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_pulses(input logic [7:0] b);
    return 1 + 8 - $countones(b);
  endfunction

  function automatic int exp_width(input bit frac, input int d);
    return frac ? 3 * P : FIX * (d + 1);
  endfunction

  task automatic wr_reg(input logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic send_bit(input logic b, input bit drive);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      baud_tick16 = 1'b1;
      if (i == 0 && drive) uart_txd = b;
      @(negedge clk);
      baud_tick16 = 1'b0;
      repeat (P - 2) @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [7:0] b);
    send_bit(1'b0, 1'b1);
    for (int i = 0; i < 8; i++) send_bit(b[i], 1'b1);
    send_bit(1'b1, 1'b1);
    send_bit(1'b1, 1'b0);
  endtask

  // strobes every P clocks; pin_rx pulses of 3 clocks at offsets a1, a2
  task automatic rx_run_cycles(input int n, input int a1, input int a2);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      baud_tick16 = (c % P == 0);
      pin_rx = (a1 >= 0 && c >= a1 && c < a1 + 3) || (a2 >= 0 && c >= a2 && c < a2 + 3);
    end
    baud_tick16 = 1'b0;
  endtask

  task automatic tx_frame_check(input logic [7:0] b, input bit frac, input int d);
    int base;
    wr_reg({1'b0, 1'b1, frac, d[4:0]});
    repeat (4) @(negedge clk);
    base = tx_n;
    send_frame(b);
    chk(tx_n - base == exp_pulses(b), frac ? "R5/R6 pulse count" : "R6 pulse count",
        tx_n - base, exp_pulses(b));
    for (int k = base; k < tx_n; k++)
      chk(tx_w[k % 256] == exp_width(frac, d), frac ? "R5 width" : "R7 width",
          tx_w[k % 256], exp_width(frac, d));
  endtask

  initial begin
    logic [7:0] v;
    int base, lows, a2;
    logic prev;
    void'($urandom(32'd4711));

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);

    // R1 reset state
    chk(reg_rdata == 8'h0F, "R1 reset value", reg_rdata, 8'h0F);
    chk(pin_tx == 1'b1, "R1 disabled tx follows uart", pin_tx, 1);
    chk(uart_rxd == 1'b0, "R1 disabled rx follows pin", uart_rxd, 0);

    // R2 register readback, bit 7 forced to zero (enable kept 0)
    for (int i = 0; i < 8; i++) begin
      v = 8'($urandom) & 8'hBF;
      if (i == 0) v = 8'hBF;
      wr_reg(v);
      chk(reg_rdata == {1'b0, v[6:0]}, "R2 readback", reg_rdata, {1'b0, v[6:0]});
    end

    // R3 bypass both directions
    prev = uart_txd;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(pin_tx == prev, "R3 tx bypass", pin_tx, prev);
      chk(uart_rxd == pin_rx, "R3 rx bypass", uart_rxd, pin_rx);
      prev = 1'($urandom);
      uart_txd = prev;
      pin_rx = 1'($urandom);
    end
    @(negedge clk);
    uart_txd = 1'b1; pin_rx = 1'b0;
    repeat (3) @(negedge clk);

    // R4 enabled idle
    wr_reg(8'h60);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(pin_tx == 1'b0 && uart_rxd == 1'b1, "R4 idle levels", {pin_tx, uart_rxd}, 2'b01);
    end

    // R5/R6/R7 directed corners then random frames
    tx_frame_check(8'h00, 1'b1, 0);
    tx_frame_check(8'hFF, 1'b1, 0);
    tx_frame_check(8'h55, 1'b0, 0);
    tx_frame_check(8'h0F, 1'b0, 20);
    for (int i = 0; i < 6; i++)
      tx_frame_check(8'($urandom), 1'($urandom), int'($urandom % 21));

    // R8 single stretch
    wr_reg(8'h60);
    base = rx_n;
    rx_run_cycles(20 * P, 5 + int'($urandom % P), -1);
    chk(rx_n - base == 1, "R8 stretch count", rx_n - base, 1);
    chk(rx_w[base % 256] > 15 * P && rx_w[base % 256] <= 16 * P, "R8 stretch width",
        rx_w[base % 256], 16 * P);

    // R9 retrigger during stretch
    base = rx_n;
    a2 = 3 + 8 * P + int'($urandom % P);
    rx_run_cycles(30 * P, 3, a2);
    chk(rx_n - base == 1, "R9 merged stretch count", rx_n - base, 1);
    chk(rx_w[base % 256] > a2 - 3 + 15 * P && rx_w[base % 256] <= a2 - 3 + 16 * P,
        "R9 restarted width", rx_w[base % 256], a2 - 3 + 16 * P);

    // R10 enable toggle cancels receive stretch
    rx_run_cycles(4 * P, 2, -1);
    wr_reg(8'h20);
    wr_reg(8'h60);
    @(negedge clk);
    lows = 0;
    for (int i = 0; i < 20 * P; i++) begin
      @(negedge clk);
      if (!uart_rxd) lows++;
    end
    chk(lows == 0, "R10 stretch cancelled", lows, 0);

    // R10 enable toggle cancels fixed-width transmit pulse
    wr_reg(8'h54);
    repeat (3) @(negedge clk);
    baud_tick16 = 1'b1; uart_txd = 1'b0;
    @(negedge clk); baud_tick16 = 1'b0;
    repeat (20) @(negedge clk);
    chk(pin_tx == 1'b1, "R7 pulse in progress", pin_tx, 1);
    wr_reg(8'h14);
    wr_reg(8'h54);
    lows = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (pin_tx) lows++;
    end
    chk(lows == 0, "R10 pulse cancelled", lows, 0);
    uart_txd = 1'b1;
    repeat (5) @(negedge clk);

    summary();
    $finish;
  end

endmodule